// File: doc/BRIEF.md
# LCD blink and screen-scroll timer

This block decides, once per clock, whether a multiplexed segment display should be lit and which of four stored screens it should show. It receives a slow timebase pulse every eighth of a second, together with configuration fields held by the display controller: a blink enable, a 2-bit blink-mode field, a 2-bit rate field, a scroll enable and a 2-bit software screen number. It produces a registered lit flag and a registered screen index. The waveform generator that drives segments and commons, the screen memory, and the processor bus decode all sit outside it.

One interval generator serves every timed behaviour. The mode decode picks an interval length in timebase pulses. In blinking it toggles the lit flag at the end of each interval. In scrolling it advances the screen index instead, and the display stays lit. With blinking disabled the display is lit steadily. When the upper mode bit is clear, firmware sets the blink rate itself by writing the lower mode bit, and the display follows that bit.

Changing the selection restarts the interval count. The first interval after a change is therefore always full length, and a blinking display always starts that interval lit.

Top module: `seg_lcd_anim_timer`

## Requirements
- R1: With blink enable low, the lit flag is 1 and the screen index equals the software screen field one clock after the inputs, whatever the other fields hold.
- R2: With blink enable high and mode bit 1 low, the display is in software blink: the lit flag equals mode bit 0 one clock later, and the screen index equals the software screen field.
- R3: With blink enable high and mode = 2'b10, automatic blink runs at 1 Hz. The lit flag is 1 for the first 4 timebase pulses after the mode is selected, then toggles after every further 4 pulses.
- R4: With blink enable high, mode = 2'b11 and scroll enable low, automatic blink toggles the lit flag every (rate+2)*4 pulses. This gives 0.5, 1/3, 1/4 and 1/5 Hz for rate field values 0 to 3. The flag is 1 during the first interval.
- R5: Scroll mode requires scroll enable, blink enable and mode = 2'b11 together. In scroll mode the lit flag is 1, and the screen index advances by one after every (rate+2)*8 pulses and at no other time.
- R6: In scroll mode the screen index wraps from 3 to 0.
- R7: Outside scroll mode the screen index equals the software screen field. The scroll counter is held at 0, so the index is 0 on entry into scroll mode.
- R8: Any change of the selected behaviour or interval length restarts the interval. The next change of output needs a full new interval of pulses, and an automatic blink restarts lit.
- R9: Timebase pulses have no effect on either output in steady or software blink mode.
- R10: While reset is high, the outputs are lit flag 1 and screen index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase pulse, every 1/8 s |
| blink_en | input | 1 | Master enable for blinking and scrolling |
| mode | input | 2 | Blink-mode field; bit 0 is the software lit bit |
| freq | input | 2 | Rate field for mode 2'b11 |
| scroll_en | input | 1 | Request automatic screen scrolling |
| sw_screen | input | 2 | Screen chosen by software |
| disp_on | output | 1 | Registered lit flag |
| screen_idx | output | 2 | Registered index of the screen shown |

## Verification
The hardest states to reach from the ports are the mid-interval rate change and the scroll wrap at the slowest rate. The first needs the lit flag or screen index to be part way through an interval when the rate field changes. The second needs 160 timebase pulses of unbroken scrolling before the index returns to 0. The stimulus counts pulses from a known restart point and switches the rate after a chosen number of pulses. The expected lit flag and screen are computed as the pulse count divided by the interval length, taking the parity for blinking and the value modulo four for scrolling. Each rate is run for several full intervals, past at least one toggle or wrap.

// File: rtl/sla_pkg.sv
`timescale 1ns/1ps
package sla_pkg;

  // Behaviour chosen by the configuration fields
  typedef enum logic [1:0] {
    DISP_STEADY    = 2'd0,
    DISP_SWBLINK   = 2'd1,
    DISP_AUTOBLINK = 2'd2,
    DISP_SCROLL    = 2'd3
  } disp_kind_e;

  // Half period of an automatic blink, in timebase pulses
  function automatic int blink_half(input logic [1:0] mode, input logic [1:0] freq,
                                    input int tps);
    if (mode == 2'b10) return tps / 2;
    return (int'(freq) + 2) * tps / 2;
  endfunction

  // Dwell time of one screen while scrolling, in timebase pulses
  function automatic int scroll_dwell(input logic [1:0] freq, input int tps);
    return (int'(freq) + 2) * tps;
  endfunction

endpackage

// File: rtl/sla_mode_decode.sv
`timescale 1ns/1ps
module sla_mode_decode
  import sla_pkg::*;
#(
  parameter int TICKS_PER_SEC = 8,
  parameter int CW            = 6
) (
  input  logic          blink_en,
  input  logic          scroll_en,
  input  logic [1:0]    mode,
  input  logic [1:0]    freq,
  output disp_kind_e    kind,
  output logic [CW-1:0] limit
);

  always_comb begin
    kind  = DISP_STEADY;
    limit = CW'(1);
    if (blink_en) begin
      if (!mode[1]) begin
        kind = DISP_SWBLINK;
      end else if (mode[0] && scroll_en) begin
        kind  = DISP_SCROLL;
        limit = CW'(scroll_dwell(freq, TICKS_PER_SEC));
      end else begin
        kind  = DISP_AUTOBLINK;
        limit = CW'(blink_half(mode, freq, TICKS_PER_SEC));
      end
    end
  end

endmodule

// File: rtl/sla_interval_ctr.sv
`timescale 1ns/1ps
module sla_interval_ctr
  import sla_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  disp_kind_e    kind,
  input  logic [CW-1:0] limit,
  output logic          restart,
  output logic          evt
);

  disp_kind_e    kind_q;
  logic [CW-1:0] lim_q;
  logic [CW-1:0] cnt;
  logic          timed;
  logic          at_end;

  assign timed   = (kind == DISP_AUTOBLINK) || (kind == DISP_SCROLL);
  // a new selection is detected against the one seen last cycle
  assign restart = (kind != kind_q) || (limit != lim_q);
  assign at_end  = (cnt == limit - CW'(1));
  assign evt     = tick && timed && !restart && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= DISP_STEADY;
      lim_q  <= CW'(1);
      cnt    <= '0;
    end else begin
      kind_q <= kind;
      lim_q  <= limit;
      if (restart || !timed) begin
        cnt <= '0;
      end else if (tick) begin
        cnt <= at_end ? '0 : cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/sla_disp_out.sv
`timescale 1ns/1ps
module sla_disp_out
  import sla_pkg::*;
#(
  parameter int SCREENS = 4,
  parameter int SW      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  disp_kind_e    kind,
  input  logic          restart,
  input  logic          evt,
  input  logic          sw_bit,
  input  logic [SW-1:0] sw_screen,
  output logic          disp_on,
  output logic [SW-1:0] screen_idx
);

  logic          phase, phase_n;
  logic [SW-1:0] scr, scr_n, scr_inc;
  logic          disp_n;
  logic [SW-1:0] screen_n;

  generate
    if ((1 << SW) == SCREENS) begin : g_pow2
      assign scr_inc = scr + SW'(1);
    end else begin : g_cmp
      assign scr_inc = (scr == SW'(SCREENS - 1)) ? '0 : scr + SW'(1);
    end
  endgenerate

  always_comb begin
    phase_n = phase;
    if (kind != DISP_AUTOBLINK || restart) phase_n = 1'b1;
    else if (evt)                          phase_n = ~phase;

    scr_n = scr;
    if (kind != DISP_SCROLL) scr_n = '0;
    else if (evt)            scr_n = scr_inc;

    case (kind)
      DISP_SWBLINK:   disp_n = sw_bit;
      DISP_AUTOBLINK: disp_n = phase_n;
      default:        disp_n = 1'b1;
    endcase

    screen_n = (kind == DISP_SCROLL) ? scr_n : sw_screen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= 1'b1;
      scr        <= '0;
      disp_on    <= 1'b1;
      screen_idx <= '0;
    end else begin
      phase      <= phase_n;
      scr        <= scr_n;
      disp_on    <= disp_n;
      screen_idx <= screen_n;
    end
  end

endmodule

// File: rtl/seg_lcd_anim_timer.sv
`timescale 1ns/1ps
module seg_lcd_anim_timer
  import sla_pkg::*;
#(
  parameter  int TICKS_PER_SEC = 8,
  parameter  int SCREENS       = 4,
  localparam int SW            = $clog2(SCREENS),
  localparam int MAX_LIMIT     = 5 * TICKS_PER_SEC,
  localparam int CW            = $clog2(MAX_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          blink_en,
  input  logic [1:0]    mode,
  input  logic [1:0]    freq,
  input  logic          scroll_en,
  input  logic [SW-1:0] sw_screen,
  output logic          disp_on,
  output logic [SW-1:0] screen_idx
);

  disp_kind_e    kind;
  logic [CW-1:0] limit;
  logic          restart;
  logic          evt;

  sla_mode_decode #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .CW           (CW)
  ) decode_i (
    .blink_en (blink_en),
    .scroll_en(scroll_en),
    .mode     (mode),
    .freq     (freq),
    .kind     (kind),
    .limit    (limit)
  );

  sla_interval_ctr #(
    .CW(CW)
  ) ctr_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .kind   (kind),
    .limit  (limit),
    .restart(restart),
    .evt    (evt)
  );

  sla_disp_out #(
    .SCREENS(SCREENS),
    .SW     (SW)
  ) out_i (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .restart   (restart),
    .evt       (evt),
    .sw_bit    (mode[0]),
    .sw_screen (sw_screen),
    .disp_on   (disp_on),
    .screen_idx(screen_idx)
  );

endmodule

// File: rtl/sla_anim_chk.sv
`timescale 1ns/1ps
module sla_anim_chk #(
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          blink_en,
  input logic [1:0]    mode,
  input logic          scroll_en,
  input logic [SW-1:0] sw_screen,
  input logic          disp_on,
  input logic [SW-1:0] screen_idx
);

  logic scroll_req;
  logic sc_q;

  assign scroll_req = blink_en && scroll_en && (mode == 2'b11);

  // outputs of this cycle were formed from inputs seen last cycle
  always_ff @(posedge clk) begin
    if (rst) sc_q <= 1'b0;
    else     sc_q <= scroll_req;
  end

  // R10
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (disp_on && screen_idx == '0));

  // R1
  steady_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !blink_en |=> (disp_on && screen_idx == $past(sw_screen)));

  // R2
  sw_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (blink_en && !mode[1]) |=> (disp_on == $past(mode[0])));

  // R5
  scroll_lit_chk: assert property (@(posedge clk) disable iff (rst)
    scroll_req |=> disp_on);

  // R7
  nonscroll_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !scroll_req |=> (screen_idx == $past(sw_screen)));

  // R7
  scroll_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (sc_q && !$past(sc_q)) |-> (screen_idx == '0));

  // R6
  scroll_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sc_q && $past(sc_q)) |->
      (screen_idx == $past(screen_idx) || screen_idx == $past(screen_idx) + SW'(1)
       || screen_idx == '0));

  // R5
  scroll_tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    (sc_q && $past(sc_q) && !$past(tick)) |-> $stable(screen_idx));

endmodule

bind seg_lcd_anim_timer sla_anim_chk #(.SW(SW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .blink_en  (blink_en),
  .mode      (mode),
  .scroll_en (scroll_en),
  .sw_screen (sw_screen),
  .disp_on   (disp_on),
  .screen_idx(screen_idx)
);

// File: tb/seg_lcd_anim_timer_tb_top.sv
`timescale 1ns/1ps
module seg_lcd_anim_timer_tb_top;

  localparam int TPS = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       blink_en = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [1:0] freq = 2'b00;
  logic       scroll_en = 1'b0;
  logic [1:0] sw_screen = 2'd2;
  logic       disp_on;
  logic [1:0] screen_idx;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  seg_lcd_anim_timer #(.TICKS_PER_SEC(TPS), .SCREENS(4)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .blink_en  (blink_en),
    .mode      (mode),
    .freq      (freq),
    .scroll_en (scroll_en),
    .sw_screen (sw_screen),
    .disp_on   (disp_on),
    .screen_idx(screen_idx)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive a configuration and wait until the registered outputs reflect it
  task automatic set_cfg(input logic be, input logic se, input logic [1:0] m,
                         input logic [1:0] f, input logic [1:0] s);
    @(negedge clk);
    blink_en = be; scroll_en = se; mode = m; freq = f; sw_screen = s;
    @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  initial begin
    // R10: reset values while inputs request software blink with lit bit 0
    repeat (3) @(negedge clk);
    check("R10 disp_on", int'(disp_on), 1);
    check("R10 screen_idx", int'(screen_idx), 0);
    @(negedge clk) rst = 1'b0;
    set_cfg(0, 0, 0, 0, 0);

    // R1: steady display for every combination of the other fields
    for (int m = 0; m < 4; m++)
      for (int se = 0; se < 2; se++)
        for (int s = 0; s < 4; s++) begin
          set_cfg(0, se[0], m[1:0], m[1:0], s[1:0]);
          check("R1 disp_on", int'(disp_on), 1);
          check("R1 screen_idx", int'(screen_idx), s);
        end

    // R2: software blink follows mode bit 0
    for (int m = 0; m < 2; m++)
      for (int se = 0; se < 2; se++)
        for (int s = 0; s < 4; s++) begin
          set_cfg(1, se[0], m[1:0], 2'd2, s[1:0]);
          check("R2 disp_on", int'(disp_on), m);
          check("R2 screen_idx", int'(screen_idx), s);
        end

    // R9: pulses ignored in steady and software blink
    set_cfg(0, 1, 3, 3, 2);
    for (int j = 0; j < 60; j++) begin
      pulse();
      check("R9 steady disp_on", int'(disp_on), 1);
      check("R9 steady screen_idx", int'(screen_idx), 2);
    end
    set_cfg(1, 1, 1, 3, 1);
    for (int j = 0; j < 45; j++) begin
      pulse();
      check("R9 swblink lit disp_on", int'(disp_on), 1);
      check("R9 swblink screen_idx", int'(screen_idx), 1);
    end
    set_cfg(1, 1, 0, 3, 1);
    for (int j = 0; j < 45; j++) begin
      pulse();
      check("R9 swblink dark disp_on", int'(disp_on), 0);
    end

    // R3 / R4: automatic blink at every rate
    for (int r = 0; r < 5; r++) begin
      int f, h;
      logic [1:0] m;
      string tag;
      m   = (r == 0) ? 2'b10 : 2'b11;
      f   = (r == 0) ? 0 : r - 1;
      h   = (r == 0) ? TPS / 2 : (f + 2) * TPS / 2;
      tag = (r == 0) ? "R3" : "R4";
      set_cfg(0, 0, 0, 0, 0);
      set_cfg(1, 0, m, f[1:0], r[1:0]);
      check({tag, " start lit"}, int'(disp_on), 1);
      for (int j = 1; j <= 3 * h; j++) begin
        pulse();
        check({tag, " disp_on"}, int'(disp_on), ((j / h) % 2 == 0) ? 1 : 0);
        check("R7 blink screen_idx", int'(screen_idx), r % 4);
      end
    end

    // R5 / R6: scrolling at every rate, through a wrap
    for (int f = 0; f < 4; f++) begin
      int d;
      d = (f + 2) * TPS;
      set_cfg(0, 0, 0, 0, 0);
      set_cfg(1, 1, 3, f[1:0], 3);
      check("R7 scroll entry screen_idx", int'(screen_idx), 0);
      for (int j = 1; j <= 5 * d; j++) begin
        pulse();
        check("R5 scroll disp_on", int'(disp_on), 1);
        if (j / d >= 4) check("R6 wrap screen_idx", int'(screen_idx), (j / d) % 4);
        else            check("R5 scroll screen_idx", int'(screen_idx), j / d);
      end
    end

    // R7: leaving scroll clears the index, software screen takes over
    set_cfg(0, 0, 0, 0, 0);
    set_cfg(1, 1, 3, 0, 3);
    for (int j = 0; j < 2 * 2 * TPS; j++) pulse();
    check("R7 before exit screen_idx", int'(screen_idx), 2);
    set_cfg(1, 0, 3, 0, 3);
    check("R7 exit screen_idx", int'(screen_idx), 3);
    set_cfg(1, 1, 3, 0, 1);
    check("R7 reentry screen_idx", int'(screen_idx), 0);

    // R8: rate change mid-interval while blinking dark
    set_cfg(0, 0, 0, 0, 0);
    set_cfg(1, 0, 3, 0, 0);
    for (int j = 0; j < 10; j++) pulse();
    check("R8 dark before change", int'(disp_on), 0);
    set_cfg(1, 0, 3, 1, 0);
    check("R8 lit after change", int'(disp_on), 1);
    for (int j = 1; j <= 12; j++) begin
      pulse();
      check("R8 full first interval", int'(disp_on), (j < 12) ? 1 : 0);
    end

    // R8: rate change mid-dwell while scrolling
    set_cfg(0, 0, 0, 0, 0);
    set_cfg(1, 1, 3, 0, 0);
    for (int j = 0; j < 20; j++) pulse();
    check("R8 scroll before change", int'(screen_idx), 1);
    set_cfg(1, 1, 3, 1, 0);
    check("R8 scroll kept index", int'(screen_idx), 1);
    for (int j = 1; j <= 24; j++) begin
      pulse();
      check("R8 scroll full dwell", int'(screen_idx), (j < 24) ? 1 : 2);
    end

    // R10: reset again from a scrolling, advanced state
    for (int j = 0; j < 24; j++) pulse();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R10 re-reset disp_on", int'(disp_on), 1);
    check("R10 re-reset screen_idx", int'(screen_idx), 0);
    @(negedge clk) rst = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule